// File: doc/BRIEF.md
# Dual-Bank Flash Command Decoder

This block sits on the write side of a two-bank flash device and interprets the bus write cycles it sees. Each accepted write carries an address and a data byte. A fixed two-write unlock prefix must come before any command, and a state machine steps through that prefix. After the prefix, one more write selects one of four actions: program setup, identification entry for one bank, secure-overlay enable or secure-overlay disable. A reset byte written at any point outside program setup abandons the sequence in progress and leaves identification mode. It does not change the secure-overlay enable.

Reads use a combinational path. The read address is passed to the array model, and the block returns either the array byte or an identification code. Identification codes are returned only while identification mode is active and only when the read hits the bank that was latched by the identification command. The four-write program sequence raises a program request toward the array model. That request carries the address and data of the final write and follows valid/ready rules. While the request is pending, `wr_ready` is held low, so command writes are stalled rather than lost.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the decoder is in the read-array state: `id_active`=0, `sec_en`=0, `prog_valid`=0, `wr_ready`=1, and `rd_data` equals `arr_rdata` for any address.
- R2: The unlock prefix is two writes: data AAh at offset 555h, then data 55h at offset 2AAh. The offset is address bits [10:0]. Bits between bit 10 and the bank bit are ignored, and so is the bank bit. A third write of 90h at offset 555h sets `id_active`. It also latches that write's address MSB as the identification bank.
- R3: While `id_active` is 1, reads in the identification bank return codes selected by address bits [7:0]. Offset 00h returns the manufacturer code. Offsets 01h, 0Eh and 0Fh return device-ID bytes 0, 1 and 2. Every other offset returns 0.
- R4: While `id_active` is 1, reads of the other bank return `arr_rdata` for the same address. `arr_addr` always equals `rd_addr`.
- R5: Identification mode persists across reads and across any writes other than the reset byte. A new identification command re-latches the bank.
- R6: A write of F0h at any address outside program setup returns the decoder to the read-array state. The next cycle `id_active` is 0, and any partial unlock is discarded.
- R7: After the prefix, writing 88h at offset 555h sets `sec_en`, and writing 8Ch at offset 555h clears it. No other write changes `sec_en`, including the reset byte.
- R8: A write that does not match the next expected step of a sequence returns the decoder to the read-array state without side effects.
- R9: A program uses four writes: the prefix, then A0h at offset 555h, then any write. The cycle after the fourth write is accepted, `prog_valid` is 1 and `prog_addr`/`prog_data` hold that write's address and data. The fourth write is never decoded as a command.
- R10: While `prog_valid` is 1 and `prog_ready` is 0, the request holds with stable address and data, and `wr_ready` stays 0. `prog_valid` falls the cycle after `prog_ready` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write cycle offered |
| wr_ready | output | 1 | Write cycle can be accepted (low while a program request is pending) |
| wr_addr | input | ADDR_W | Write address; MSB is the bank |
| wr_data | input | DATA_W | Write data / command byte |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read result (array data or identification code) |
| arr_addr | output | ADDR_W | Address forwarded to the array model |
| arr_rdata | input | DATA_W | Array data for `arr_addr` |
| prog_valid | output | 1 | Program request pending |
| prog_ready | input | 1 | Array model takes the program request |
| prog_addr | output | ADDR_W | Program target address |
| prog_data | output | DATA_W | Program data |
| id_active | output | 1 | Identification mode active |
| sec_en | output | 1 | Secure-overlay enable |

## Verification
Some behaviour is checked by the assertions on every cycle. They confirm that a pending program request stalls writes and holds its address and data. They confirm that the reset byte never disturbs the secure-overlay enable and ends identification mode. They confirm that reads of the non-identification bank pass array data through. Other behaviour can only be shown by the bench's scenarios. These include the exact code at each identification offset and the choice of bank from the command address. They also include the way a broken or reset-interrupted unlock prefix is discarded, and the fact that the fourth program write is taken as data even when it looks like a command byte.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {
    ST_READ  = 2'd0,
    ST_UNL1  = 2'd1,
    ST_UNL2  = 2'd2,
    ST_SETUP = 2'd3
  } seq_st_t;

  localparam int CMD_OFS_W = 11;
  localparam logic [CMD_OFS_W-1:0] OFS_FIRST  = 11'h555;
  localparam logic [CMD_OFS_W-1:0] OFS_SECOND = 11'h2AA;

  localparam logic [7:0] BYTE_UNLK_A  = 8'hAA;
  localparam logic [7:0] BYTE_UNLK_B  = 8'h55;
  localparam logic [7:0] BYTE_PROG    = 8'hA0;
  localparam logic [7:0] BYTE_IDENT   = 8'h90;
  localparam logic [7:0] BYTE_RESET   = 8'hF0;
  localparam logic [7:0] BYTE_SEC_ON  = 8'h88;
  localparam logic [7:0] BYTE_SEC_OFF = 8'h8C;

  localparam int ID_OFS_W = 8;
endpackage

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cmd_ident,
  output logic              cmd_reset,
  output logic              cmd_sec_on,
  output logic              cmd_sec_off,
  output logic              cmd_prog,
  output logic              in_setup
);
  seq_st_t st, st_nxt;
  logic [7:0]           cbyte;
  logic [CMD_OFS_W-1:0] ofs;

  assign cbyte    = wr_data[7:0];
  assign ofs      = wr_addr[CMD_OFS_W-1:0];
  assign in_setup = (st == ST_SETUP);

  always_comb begin
    st_nxt      = st;
    cmd_ident   = 1'b0;
    cmd_reset   = 1'b0;
    cmd_sec_on  = 1'b0;
    cmd_sec_off = 1'b0;
    cmd_prog    = 1'b0;
    if (wr_fire) begin
      if (st == ST_SETUP) begin
        cmd_prog = 1'b1;
        st_nxt   = ST_READ;
      end else if (cbyte == BYTE_RESET) begin
        cmd_reset = 1'b1;
        st_nxt    = ST_READ;
      end else begin
        case (st)
          ST_READ: st_nxt = (cbyte == BYTE_UNLK_A && ofs == OFS_FIRST) ? ST_UNL1 : ST_READ;
          ST_UNL1: st_nxt = (cbyte == BYTE_UNLK_B && ofs == OFS_SECOND) ? ST_UNL2 : ST_READ;
          ST_UNL2: begin
            st_nxt = ST_READ;
            if (ofs == OFS_FIRST) begin
              case (cbyte)
                BYTE_PROG:    st_nxt = ST_SETUP;
                BYTE_IDENT:   cmd_ident = 1'b1;
                BYTE_SEC_ON:  cmd_sec_on = 1'b1;
                BYTE_SEC_OFF: cmd_sec_off = 1'b1;
                default:      st_nxt = ST_READ;
              endcase
            end
          end
          default: st_nxt = ST_READ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_READ;
    else        st <= st_nxt;
  end
endmodule

// File: rtl/flash_mode_regs.sv
module flash_mode_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_ident,
  input  logic cmd_reset,
  input  logic cmd_sec_on,
  input  logic cmd_sec_off,
  input  logic wr_bank,
  output logic id_en,
  output logic id_bank,
  output logic sec_en
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_en   <= 1'b0;
      id_bank <= 1'b0;
    end else if (cmd_reset) begin
      id_en <= 1'b0;
    end else if (cmd_ident) begin
      id_en   <= 1'b1;
      id_bank <= wr_bank;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           sec_en <= 1'b0;
    else if (cmd_sec_on)  sec_en <= 1'b1;
    else if (cmd_sec_off) sec_en <= 1'b0;
  end
endmodule

// File: rtl/flash_id_readmux.sv
module flash_id_readmux
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter int          DATA_W  = 8,
  parameter logic [7:0]  MFR_ID  = 8'h01,
  parameter logic [7:0]  DEV_ID0 = 8'h7E,
  parameter logic [7:0]  DEV_ID1 = 8'h21,
  parameter logic [7:0]  DEV_ID2 = 8'h02
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic              id_en,
  input  logic              id_bank,
  output logic [DATA_W-1:0] rd_data
);
  logic [7:0]          code8;
  logic [DATA_W-1:0]   code;
  logic                hit;

  always_comb begin
    case (rd_addr[ID_OFS_W-1:0])
      8'h00:   code8 = MFR_ID;
      8'h01:   code8 = DEV_ID0;
      8'h0E:   code8 = DEV_ID1;
      8'h0F:   code8 = DEV_ID2;
      default: code8 = 8'h00;
    endcase
  end

  generate
    if (DATA_W > 8) begin : g_wide
      assign code = {{(DATA_W-8){1'b0}}, code8};
    end else begin : g_byte
      assign code = code8[DATA_W-1:0];
    end
  endgenerate

  assign hit     = id_en && (rd_addr[ADDR_W-1] == id_bank);
  assign rd_data = hit ? code : arr_rdata;
endmodule

// File: rtl/flash_prog_stage.sv
module flash_prog_stage #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_prog,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              prog_valid,
  input  logic              prog_ready,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_valid <= 1'b0;
      prog_addr  <= '0;
      prog_data  <= '0;
    end else if (cmd_prog) begin
      prog_valid <= 1'b1;
      prog_addr  <= wr_addr;
      prog_data  <= wr_data;
    end else if (prog_valid && prog_ready) begin
      prog_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int         ADDR_W  = 16,
  parameter int         DATA_W  = 8,
  parameter logic [7:0] MFR_ID  = 8'h01,
  parameter logic [7:0] DEV_ID0 = 8'h7E,
  parameter logic [7:0] DEV_ID1 = 8'h21,
  parameter logic [7:0] DEV_ID2 = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              prog_valid,
  input  logic              prog_ready,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              id_active,
  output logic              sec_en
);
  logic wr_fire;
  logic cmd_ident, cmd_reset, cmd_sec_on, cmd_sec_off, cmd_prog;
  logic setup_armed;
  logic id_bank;

  assign wr_ready = !prog_valid;
  assign wr_fire  = wr_valid && wr_ready;
  assign arr_addr = rd_addr;

  flash_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_ident(cmd_ident), .cmd_reset(cmd_reset),
    .cmd_sec_on(cmd_sec_on), .cmd_sec_off(cmd_sec_off),
    .cmd_prog(cmd_prog), .in_setup(setup_armed)
  );

  flash_mode_regs u_mode (
    .clk(clk), .rst_n(rst_n),
    .cmd_ident(cmd_ident), .cmd_reset(cmd_reset),
    .cmd_sec_on(cmd_sec_on), .cmd_sec_off(cmd_sec_off),
    .wr_bank(wr_addr[ADDR_W-1]),
    .id_en(id_active), .id_bank(id_bank), .sec_en(sec_en)
  );

  flash_id_readmux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MFR_ID(MFR_ID),
    .DEV_ID0(DEV_ID0), .DEV_ID1(DEV_ID1), .DEV_ID2(DEV_ID2)
  ) u_rd (
    .rd_addr(rd_addr), .arr_rdata(arr_rdata),
    .id_en(id_active), .id_bank(id_bank), .rd_data(rd_data)
  );

  flash_prog_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_prog (
    .clk(clk), .rst_n(rst_n), .cmd_prog(cmd_prog),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_valid(prog_valid), .prog_ready(prog_ready),
    .prog_addr(prog_addr), .prog_data(prog_data)
  );
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] arr_rdata,
  input logic              prog_valid,
  input logic              prog_ready,
  input logic [ADDR_W-1:0] prog_addr,
  input logic [DATA_W-1:0] prog_data,
  input logic              id_active,
  input logic              id_bank,
  input logic              sec_en,
  input logic              setup_armed
);
  logic reset_write;
  assign reset_write = wr_valid && wr_ready && (wr_data[7:0] == 8'hF0) && !setup_armed;

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    prog_valid |-> !wr_ready);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_valid && !prog_ready) |=> (prog_valid && $stable(prog_addr) && $stable(prog_data)));

  p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_valid && prog_ready) |=> !prog_valid);

  p_rise_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_valid) |-> $past(wr_valid && wr_ready));

  p_reset_keeps_sec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_write |=> $stable(sec_en));

  p_reset_ends_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reset_write |=> !id_active);

  p_other_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (id_active && (rd_addr[ADDR_W-1] != id_bank)) |-> (rd_data == arr_rdata));

  p_no_id_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !id_active |-> (rd_data == arr_rdata));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .arr_rdata(arr_rdata),
  .prog_valid(prog_valid), .prog_ready(prog_ready), .prog_addr(prog_addr),
  .prog_data(prog_data), .id_active(id_active), .id_bank(id_bank),
  .sec_en(sec_en), .setup_armed(setup_armed)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  localparam logic [7:0] T_MFR = 8'h01, T_D0 = 8'h7E, T_D1 = 8'h21, T_D2 = 8'h02;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic [15:0] arr_addr;
  logic [7:0]  arr_rdata;
  logic        prog_valid;
  logic        prog_ready = 1'b1;
  logic [15:0] prog_addr;
  logic [7:0]  prog_data;
  logic        id_active;
  logic        sec_en;

  int checks = 0;
  int fails  = 0;

  // bench reference state
  int   m_st = 0;
  bit   m_id = 0, m_bank = 0, m_sec = 0, m_prog = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] arr_fn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign arr_rdata = arr_fn(arr_addr);

  flash_cmd_decoder #(.ADDR_W(16), .DATA_W(8), .MFR_ID(T_MFR),
    .DEV_ID0(T_D0), .DEV_ID1(T_D1), .DEV_ID2(T_D2)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .arr_addr(arr_addr), .arr_rdata(arr_rdata), .prog_valid(prog_valid),
    .prog_ready(prog_ready), .prog_addr(prog_addr), .prog_data(prog_data),
    .id_active(id_active), .sec_en(sec_en));

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    if (m_id && a[15] == m_bank) begin
      case (a[7:0])
        8'h00: return T_MFR;
        8'h01: return T_D0;
        8'h0E: return T_D1;
        8'h0F: return T_D2;
        default: return 8'h00;
      endcase
    end
    return arr_fn(a);
  endfunction

  function automatic void model_write(input logic [15:0] a, input logic [7:0] d);
    logic [10:0] o;
    o = a[10:0];
    m_prog = 0;
    if (m_st == 3) begin m_prog = 1; m_st = 0; end
    else if (d == 8'hF0) begin m_id = 0; m_st = 0; end
    else if (m_st == 0) m_st = (d == 8'hAA && o == 11'h555) ? 1 : 0;
    else if (m_st == 1) m_st = (d == 8'h55 && o == 11'h2AA) ? 2 : 0;
    else begin
      m_st = 0;
      if (o == 11'h555) begin
        if (d == 8'hA0) m_st = 3;
        else if (d == 8'h90) begin m_id = 1; m_bank = a[15]; end
        else if (d == 8'h88) m_sec = 1;
        else if (d == 8'h8C) m_sec = 0;
      end
    end
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Drives one write; returns at the negedge after acceptance.
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    model_write(a, d);
  endtask

  task automatic unlock(input logic b);
    wr({b, 4'h0, 11'h555}, 8'hAA);
    wr({b, 4'h0, 11'h2AA}, 8'h55);
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp_rd(a));
    chk(req, arr_addr, a);
  endtask

  task automatic state_chk(input string req);
    chk(req, id_active, m_id);
    chk(req, sec_en, m_sec);
    chk(req, prog_valid, m_prog);
    if (m_prog) begin
      chk(req, prog_addr, wr_addr);
      chk(req, prog_data, wr_data);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] a;
    logic [7:0]  d;
    void'($urandom(32'd1384));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {wr_ready, prog_valid, id_active, sec_en}, 4'b1000);
    rd_chk("R1", 16'h0000);
    rd_chk("R1", 16'h8001);

    // R2/R3/R4 identification in bank 1
    unlock(1'b0);
    wr(16'h8555, 8'h90);
    state_chk("R2");
    chk("R2", id_active, 1'b1);
    rd_chk("R3", 16'h8000); chk("R3", rd_data, T_MFR);
    rd_chk("R3", 16'h8301); chk("R3", rd_data, T_D0);
    rd_chk("R3", 16'h800E); chk("R3", rd_data, T_D1);
    rd_chk("R3", 16'h800F); chk("R3", rd_data, T_D2);
    rd_chk("R3", 16'h8005); chk("R3", rd_data, 8'h00);
    rd_chk("R4", 16'h0000); chk("R4", rd_data, arr_fn(16'h0000));
    rd_chk("R4", 16'h000F);

    // R5 persists across unrelated writes, re-latch bank
    wr(16'h1234, 8'h77);
    state_chk("R5"); rd_chk("R5", 16'h8000);
    unlock(1'b1);
    wr(16'h0555, 8'h90);
    state_chk("R5"); rd_chk("R5", 16'h0001); rd_chk("R5", 16'h8001);

    // R6 reset byte ends ID, discards partial unlock
    wr(16'h4321, 8'hF0);
    state_chk("R6"); chk("R6", id_active, 1'b0); rd_chk("R6", 16'h0000);
    wr(16'h0555, 8'hAA);
    wr(16'h0000, 8'hF0);
    wr(16'h02AA, 8'h55);
    wr(16'h0555, 8'h90);
    state_chk("R6"); chk("R6", id_active, 1'b0);

    // R7 secure overlay on, survives reset, cleared by exit
    unlock(1'b0); wr(16'h0555, 8'h88);
    state_chk("R7"); chk("R7", sec_en, 1'b1);
    wr(16'h0000, 8'hF0);
    state_chk("R7"); chk("R7", sec_en, 1'b1);
    unlock(1'b0); wr(16'h0555, 8'h8C);
    state_chk("R7"); chk("R7", sec_en, 1'b0);

    // R8 broken prefix (wrong offset)
    wr(16'h0555, 8'hAA); wr(16'h02AB, 8'h55); wr(16'h0555, 8'h90);
    state_chk("R8"); chk("R8", id_active, 1'b0);

    // R9 program; fourth write looks like a command byte
    unlock(1'b1); wr(16'h8555, 8'hA0);
    wr(16'hBEEF, 8'h90);
    state_chk("R9");
    chk("R9", {prog_valid, prog_addr, prog_data}, {1'b1, 16'hBEEF, 8'h90});
    @(negedge clk);
    chk("R9", id_active, 1'b0);

    // R10 back-pressure hold
    prog_ready = 1'b0;
    unlock(1'b0); wr(16'h0555, 8'hA0); wr(16'h2468, 8'h3C);
    state_chk("R10");
    repeat (3) @(negedge clk);
    chk("R10", {prog_valid, wr_ready, prog_addr, prog_data}, {2'b10, 16'h2468, 8'h3C});
    prog_ready = 1'b1;
    @(negedge clk);
    chk("R10", {prog_valid, wr_ready}, 2'b01);
    m_prog = 0;

    // random mix
    for (int i = 0; i < 400; i++) begin
      int k;
      k = $urandom % 8;
      case (k)
        0: begin unlock($urandom % 2); wr({$urandom % 2, 4'h0, 11'h555}, 8'h90); end
        1: begin unlock($urandom % 2); wr(16'h0555, 8'hA0); wr($urandom, $urandom); end
        2: wr($urandom, 8'hF0);
        3: begin unlock(1'b0); wr(16'h8555, 8'h88); end
        4: begin unlock(1'b1); wr(16'h0555, 8'h8C); end
        default: begin
          int s;
          s = $urandom % 3;
          a = $urandom;
          if (s == 0) a[10:0] = 11'h555; else if (s == 1) a[10:0] = 11'h2AA;
          case ($urandom % 8)
            0: d = 8'hAA; 1: d = 8'h55; 2: d = 8'h90; 3: d = 8'hA0;
            4: d = 8'hF0; 5: d = 8'h88; 6: d = 8'h8C; default: d = $urandom;
          endcase
          wr(a, d);
        end
      endcase
      state_chk("R5");
      a = $urandom;
      if ($urandom % 2) a[7:0] = ($urandom % 2) ? 8'h00 : 8'h0E;
      rd_chk("R3", a);
      if (m_prog) begin @(negedge clk); m_prog = 0; end
    end

    summary();
  end
endmodule